// File: doc/BRIEF.md
# Prioritized serial interrupt identifier

This block sits beside the register file of a serial port and decides whether the port requests an interrupt and why. It holds the interrupt enable register. It watches four conditions: a receive overrun, data waiting in the receive queue, a transmit-ready event, and any change flag of the modem lines. From these it produces one interrupt request line and the identification byte that software reads to find the cause. The request line and the byte are combinational functions of the stored state and the live inputs, so they reflect every register access in the cycle that follows it.

The transmit-ready condition is not a level. It is an event flag that the block keeps itself. A write to the transmit data register sets it. So does an enable write that turns the transmit interrupt on from off. Only an identification read that actually reports the transmit cause clears it. Waiting receive data is identified with the character-timeout code, so software has one receive path whether or not the queue is enabled.

Top module: `sirq_ident`

## Requirements
- R1: After reset the stored enable value is 0, the transmit-ready flag is clear, `irq` is 0 and `iir_o` reads 0x01 while `fifo_en` is 0.
- R2: The cause in `iir_o[3:0]` follows this fixed priority, highest first: overrun with enable bit 2 set (code 0x6); receive data with enable bit 0 set; transmit-ready flag with enable bit 1 set (code 0x2); any bit of `msr_delta` with enable bit 3 set (code 0x0); otherwise none pending (code 0x1).
- R3: Waiting receive data is reported with code 0xC (character timeout), never 0x4.
- R4: `irq` is 1 exactly when the cause code differs from 0x1.
- R5: A cycle with `data_wr` high leaves the transmit-ready flag set in the next cycle. This holds even if an identification read clears it in the same cycle.
- R6: An enable write whose bit 1 goes from 0 to 1 sets the transmit-ready flag. Rewriting bit 1 while it is already 1 leaves the flag unchanged.
- R7: Enable writes keep only `wdata[3:0]`, and `ier_o[7:4]` always reads 0.
- R8: An `iir_rd` cycle whose `iir_o` shows code 0x2 clears the transmit-ready flag. An `iir_rd` cycle that shows any other code leaves the flag unchanged.
- R9: `iir_o[7:6]` is 2'b11 when `fifo_en` is 1 and 2'b00 otherwise. `iir_o[5:4]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Write strobe for the interrupt enable register |
| data_wr | input | 1 | Strobe marking a write to the transmit data register |
| iir_rd | input | 1 | Strobe marking a read of the identification byte |
| wdata | input | 8 | Write data for the enable register |
| overrun | input | 1 | Receive overrun flag from line status |
| rx_avail | input | 1 | Receive queue holds at least one character |
| msr_delta | input | 4 | Modem line change flags |
| fifo_en | input | 1 | Queue enable state from the FIFO control register |
| ier_o | output | 8 | Enable register readback |
| iir_o | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request line |

## Verification
The bench sweeps every enable value against every combination of overrun, receive data, transmit flag, modem change and queue enable. A wrong priority order would show a lower cause over a higher one, and using the plain data-available code would show 0x4 where 0xC is expected. The flag is probed at its edges. An enable rewrite with bit 1 already set must not re-arm it. An identification read that reports receive data must not consume the transmit event. A data write that arrives in the same cycle as the clearing read must survive. A design that got any of these wrong would lose or duplicate transmit interrupts.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int DATA_W  = 8;
    localparam int EN_W    = 4;
    localparam int NSRC    = 4;
    localparam int SRC_IW  = $clog2(NSRC);

    // cause codes in the low nibble of the identification byte
    localparam logic [3:0] CODE_NONE = 4'h1;
    localparam logic [3:0] CODE_LINE = 4'h6;
    localparam logic [3:0] CODE_RXTO = 4'hC;
    localparam logic [3:0] CODE_TXE  = 4'h2;
    localparam logic [3:0] CODE_MDM  = 4'h0;
    localparam logic [7:0] FIFO_IND  = 8'hC0;

    // enable bit positions
    localparam int EN_RX  = 0;
    localparam int EN_TX  = 1;
    localparam int EN_LS  = 2;
    localparam int EN_MDM = 3;

    // source index = priority rank (0 highest)
    localparam int SRC_LINE = 0;
    localparam int SRC_RX   = 1;
    localparam int SRC_TX   = 2;
    localparam int SRC_MDM  = 3;

    typedef struct packed {
        logic [EN_W-1:0] en;
    } en_state_t;

    function automatic logic [3:0] src_code(input logic [SRC_IW-1:0] idx);
        case (idx)
            SRC_IW'(SRC_LINE): src_code = CODE_LINE;
            SRC_IW'(SRC_RX):   src_code = CODE_RXTO;
            SRC_IW'(SRC_TX):   src_code = CODE_TXE;
            default:           src_code = CODE_MDM;
        endcase
    endfunction
endpackage

// File: rtl/sirq_prio.sv
module sirq_prio #(
    parameter int NREQ = 4,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0] req,
    output logic            any,
    output logic [IW-1:0]   idx
);
    // lowest index wins
    always_comb begin
        idx = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/sirq_tx_flag.sv
module sirq_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic pend;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.pend = 1'b0;
        if (set_i) st_d.pend = 1'b1;   // a new event outranks consumption
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.pend;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o)); // R6
endmodule

// File: rtl/sirq_ident.sv
module sirq_ident
    import sirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic              data_wr,
    input  logic              iir_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              overrun,
    input  logic              rx_avail,
    input  logic [3:0]        msr_delta,
    input  logic              fifo_en,
    output logic [DATA_W-1:0] ier_o,
    output logic [DATA_W-1:0] iir_o,
    output logic              irq
);
    en_state_t st_d, st_q;

    logic              tx_pend;
    logic              tx_set, tx_clr;
    logic [NSRC-1:0]   req;
    logic              any_req;
    logic [SRC_IW-1:0] win;
    logic [3:0]        code;

    always_comb begin
        st_d   = st_q;
        tx_set = data_wr;
        if (ier_wr) begin
            st_d.en = wdata[EN_W-1:0];
            if (!st_q.en[EN_TX] && wdata[EN_TX]) tx_set = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        req           = '0;
        req[SRC_LINE] = overrun   && st_q.en[EN_LS];
        req[SRC_RX]   = rx_avail  && st_q.en[EN_RX];
        req[SRC_TX]   = tx_pend   && st_q.en[EN_TX];
        req[SRC_MDM]  = (|msr_delta) && st_q.en[EN_MDM];
    end

    sirq_prio #(.NREQ(NSRC)) u_prio (
        .req (req),
        .any (any_req),
        .idx (win)
    );

    assign code   = any_req ? src_code(win) : CODE_NONE;
    assign tx_clr = iir_rd && (code == CODE_TXE);

    sirq_tx_flag u_txf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tx_set),
        .clr_i  (tx_clr),
        .flag_o (tx_pend)
    );

    assign ier_o = {{(DATA_W-EN_W){1'b0}}, st_q.en};
    assign iir_o = (fifo_en ? FIFO_IND : 8'h00) | {4'h0, code};
    assign irq   = any_req;

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && ier_o[2]) |-> (iir_o[3:0] == 4'h6)); // R2
    AST_RX_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && ier_o[0] && !(overrun && ier_o[2])) |-> (iir_o[3:0] == 4'hC)); // R3
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iir_o[3:0] == 4'h1)); // R4
    AST_TX_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_o[3:0] == 4'h2 && !data_wr && !ier_wr)
        |=> !(ier_o[1] && iir_o[3:0] == 4'h2 && !overrun && !rx_avail)); // R8
    AST_IER_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier_o[7:4] == 4'h0)); // R7
    AST_FIFO_IND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> (iir_o[7:6] == 2'b11)); // R9
endmodule

// File: tb/sirq_ident_bench.sv
`timescale 1ns/1ps
module sirq_ident_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0, data_wr = 1'b0, iir_rd = 1'b0;
    logic [7:0] wdata = '0;
    logic       overrun = 1'b0, rx_avail = 1'b0, fifo_en = 1'b0;
    logic [3:0] msr_delta = '0;
    logic [7:0] ier_o, iir_o;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sirq_ident u_sirq_ident (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .data_wr(data_wr),
        .iir_rd(iir_rd), .wdata(wdata), .overrun(overrun),
        .rx_avail(rx_avail), .msr_delta(msr_delta), .fifo_en(fifo_en),
        .ier_o(ier_o), .iir_o(iir_o), .irq(irq)
    );

    function automatic logic [7:0] model_iir(input logic [3:0] en, input logic ov,
        input logic rx, input logic tp, input logic [3:0] dl, input logic fe);
        logic [3:0] c;
        if (ov && en[2])            c = 4'h6;
        else if (rx && en[0])       c = 4'hC;
        else if (tp && en[1])       c = 4'h2;
        else if ((dl != 0) && en[3]) c = 4'h0;
        else                        c = 4'h1;
        return (fe ? 8'hC0 : 8'h00) | {4'h0, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle with the given strobes; inputs applied at negedge
    task automatic cyc(input logic w_ier, input logic [7:0] wd, input logic w_dat, input logic r_iir);
        @(negedge clk);
        ier_wr = w_ier; wdata = wd; data_wr = w_dat; iir_rd = r_iir;
        @(posedge clk);
        #1;
        ier_wr = 0; data_wr = 0; iir_rd = 0;
    endtask

    task automatic clear_inputs();
        overrun = 0; rx_avail = 0; msr_delta = 0; fifo_en = 0;
    endtask

    // drive flag to a known state, ending with ier = en
    task automatic setup(input logic [3:0] en, input logic pend);
        clear_inputs();
        cyc(1, 8'h02, 0, 0);
        cyc(0, 8'h00, 0, 1);   // reports 0x2 -> clears
        if (pend) cyc(0, 8'h00, 1, 0);
        cyc(1, {4'h0, en}, 0, 0); // no rising bit1 from 0x02
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ier", ier_o, 8'h00);
        chk("R1 iir", iir_o, 8'h01);
        chk("R1 irq", irq, 0);
        rst_n = 1;

        // R2 R3 R4 R9 exhaustive sweep
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 2; p++) begin
                setup(e[3:0], p[0]);
                for (int k = 0; k < 32; k++) begin
                    logic [7:0] exp;
                    @(negedge clk);
                    overrun = k[0]; rx_avail = k[1];
                    msr_delta = k[2] ? (4'h1 << k[3]) : 4'h0;
                    fifo_en = k[4];
                    #1;
                    exp = model_iir(e[3:0], k[0], k[1], p[0], msr_delta, k[4]);
                    chk("R2 iir", iir_o, exp);
                    if (k[1] && e[0] && !(k[0] && e[2])) chk("R3 rx code", iir_o[3:0], 4'hC);
                    chk("R4 irq", irq, exp[3:0] != 4'h1);
                    chk("R9 fifo bits", iir_o[7:4], k[4] ? 4'hC : 4'h0);
                end
            end
        end

        // R7 upper bits discarded
        clear_inputs();
        cyc(1, 8'hF5, 0, 0);
        chk("R7 ier readback", ier_o, 8'h05);
        cyc(1, 8'hA0, 0, 0);
        chk("R7 ier upper only", ier_o, 8'h00);

        // R5 data write sets flag
        setup(4'h2, 0);
        chk("R5 before", iir_o, 8'h01);
        cyc(0, 8'h00, 1, 0);
        chk("R5 after data write", iir_o, 8'h02);

        // R8 read reporting tx clears
        cyc(0, 8'h00, 0, 1);
        chk("R8 cleared", iir_o, 8'h01);

        // R6 rising edge sets; rewrite while high does not
        cyc(1, 8'h00, 0, 0);
        cyc(1, 8'h02, 0, 0);
        chk("R6 rising sets", iir_o, 8'h02);
        cyc(0, 8'h00, 0, 1);
        chk("R6 cleared by read", iir_o, 8'h01);
        cyc(1, 8'h02, 0, 0);
        chk("R6 rewrite no set", iir_o, 8'h01);
        cyc(1, 8'h03, 0, 0);
        chk("R6 other bit no set", iir_o, 8'h01);

        // R8 read showing rx must not consume tx
        setup(4'h3, 1);
        @(negedge clk); rx_avail = 1; #1;
        chk("R8 rx shown", iir_o, 8'h0C);
        cyc(0, 8'h00, 0, 1);
        rx_avail = 0; #1;
        chk("R8 tx kept", iir_o, 8'h02);

        // R5 set beats same-cycle clear
        cyc(0, 8'h00, 1, 1);
        chk("R5 set wins", iir_o, 8'h02);
        chk("R5 irq", irq, 1);

        // disabled tx flag stays pending for later enable
        cyc(1, 8'h00, 0, 0);
        chk("R8 masked no irq", irq, 0);
        cyc(0, 8'h00, 0, 1);
        cyc(1, 8'h02, 0, 0);
        chk("R6 pending plus rising", iir_o, 8'h02);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule